// File: doc/BRIEF.md
# Paged Edge-Detect Interrupt Controller

This block watches up to 24 general-purpose input lines, grouped into three byte-wide ports, and latches every qualifying transition into a sticky per-line event flag. Each line can be set to detect a rising or a falling transition, and each line can be enabled or masked. Latched events are summarised per port and drive a single level-sensitive interrupt request towards the host.

Software reaches the controller through a small byte-wide register window with a synchronous write strobe and a combinational read path. A page selector in the top two bits of one control byte chooses whether the three window bytes show the edge-polarity bytes, the enable bytes or the latched-event bytes. A separate read-only byte gives one pending bit per port, so the interrupt handler can find the busy port without switching pages. Events are acknowledged by writing zeros to the latched-event bytes, and an edge that arrives in the same cycle as that acknowledge is kept.

Top module: `eirq_ctrl`

## Requirements
- R1: Synchronous reset clears the page selector, all polarity bits, all enable bits and all latched events; irq is low and every readable byte reads 0x00 after reset.
- R2: A write to offset 0x07 loads the page selector from data bits 7:6; reading 0x07 returns the page in bits 7:6 and zero in bits 5:0.
- R3: With page 1 selected, offsets 0x08, 0x09 and 0x0A read and write the polarity bytes for lines 0-7, 8-15 and 16-23 (bit n of a byte is the n-th line of that port).
- R4: With page 2 selected, the same three offsets read and write the enable bytes, stored apart from the polarity bytes.
- R5: With page 3 selected, the same three offsets read the latched-event bytes with the same line-to-bit layout.
- R6: A line whose polarity bit is 1 latches an event on a low-to-high change of its synchronized level and ignores high-to-low; a polarity bit of 0 does the reverse. The event appears within four clocks of the pin change.
- R7: A transition on a line whose enable bit is 0 sets no event bit, and enabling the line afterwards does not latch the earlier transition.
- R8: A write to a latched-event byte clears the bits written as 0 and leaves the bits written as 1 unchanged; it never sets a bit.
- R9: A qualifying edge that is detected in the same cycle as a clearing write to its byte stays latched.
- R10: Offset 0x06 reads, in bit i, the OR of the event bits of port i, with bits 7:3 zero; writes to 0x06 change nothing.
- R11: irq is high exactly when at least one event bit is set.
- R12: With page 0 selected, offsets 0x08-0x0A read 0x00 and writes to them change no polarity, enable or event bit; offsets 0x00-0x05 read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_addr | input | 4 | Byte offset within the register window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| line_in | input | 24 | Asynchronous input lines, bit n is line n |
| irq | output | 1 | Interrupt request, high while any event is latched |

## Verification
Every cycle, assertions confirm that a masked line never gains an event bit, that events only leave through a write to their byte, that a detected and enabled edge is present in the event register the next cycle even under a clearing write, that a page-0 write leaves polarity and enable untouched, and that the page selector follows its write. Only the directed scenarios can show the register-window layout, the rising versus falling selection on real pin waveforms, the per-port pending summary, the bit-selective acknowledge, and the exact-cycle collision of an edge with an acknowledge.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    localparam int PORT_BITS = 8;
    localparam int NUM_PORTS = 3;
    localparam int ADDR_W    = 4;
    localparam int LINES     = PORT_BITS * NUM_PORTS;
    localparam int PAGE_W    = 2;
    localparam int ARM_DEPTH = 3;

    localparam logic [ADDR_W-1:0] OFS_PENDING = 4'h6;
    localparam logic [ADDR_W-1:0] OFS_PAGE    = 4'h7;
    localparam logic [ADDR_W-1:0] OFS_WIN     = 4'h8;

    typedef enum logic [PAGE_W-1:0] {
        PG_NONE = 2'd0,
        PG_POL  = 2'd1,
        PG_ENA  = 2'd2,
        PG_ID   = 2'd3
    } page_e;

    typedef struct packed {
        logic                 wr;
        logic [ADDR_W-1:0]    addr;
        logic [PORT_BITS-1:0] data;
    } host_req_t;

    function automatic logic [ADDR_W-1:0] win_addr(int p);
        return ADDR_W'(int'(OFS_WIN) + p);
    endfunction
endpackage

// File: rtl/eirq_edge.sv
module eirq_edge
    import eirq_pkg::*;
#(
    parameter int W = LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin,
    input  logic [W-1:0] pol,
    output logic [W-1:0] hit
);
    logic [W-1:0]           meta;
    logic [W-1:0]           lvl;
    logic [W-1:0]           prev;
    logic [ARM_DEPTH-1:0]   arm;
    logic [W-1:0]           rise;
    logic [W-1:0]           fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            lvl  <= '0;
            prev <= '0;
            arm  <= '0;
        end else begin
            meta <= pin;
            lvl  <= meta;
            prev <= lvl;
            arm  <= {arm[ARM_DEPTH-2:0], 1'b1};
        end
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;

    // per-line polarity choice; suppressed until the history is real
    for (genvar g = 0; g < W; g++) begin : g_sel
        assign hit[g] = arm[ARM_DEPTH-1] & (pol[g] ? rise[g] : fall[g]);
    end
endmodule

// File: rtl/eirq_cfg.sv
module eirq_cfg
    import eirq_pkg::*;
#(
    parameter int NP = NUM_PORTS,
    parameter int PB = PORT_BITS,
    localparam int L = NP * PB
) (
    input  logic        clk,
    input  logic        rst,
    input  host_req_t   req,
    output page_e       page,
    output logic [L-1:0] pol,
    output logic [L-1:0] en,
    output logic [NP-1:0] id_wr
);
    logic [NP-1:0] wsel;

    for (genvar g = 0; g < NP; g++) begin : g_dec
        assign wsel[g]  = req.wr && (req.addr == win_addr(g));
        assign id_wr[g] = wsel[g] && (page == PG_ID);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page <= PG_NONE;
            pol  <= '0;
            en   <= '0;
        end else begin
            if (req.wr && req.addr == OFS_PAGE)
                page <= page_e'(req.data[PB-1 -: PAGE_W]);
            for (int p = 0; p < NP; p++) begin
                if (wsel[p] && page == PG_POL) pol[p*PB +: PB] <= req.data;
                if (wsel[p] && page == PG_ENA) en[p*PB +: PB]  <= req.data;
            end
        end
    end

    assert_page_load_R2: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.addr == OFS_PAGE) |=> (page == $past(req.data[PB-1 -: PAGE_W])));

    assert_page0_inert_R12: assert property (@(posedge clk) disable iff (rst)
        (req.wr && page == PG_NONE) |=> ($stable(pol) && $stable(en)));

    assert_cfg_reset_R1: assert property (@(posedge clk)
        rst |=> (page == PG_NONE && pol == '0 && en == '0));
endmodule

// File: rtl/eirq_latch.sv
module eirq_latch
    import eirq_pkg::*;
#(
    parameter int NP = NUM_PORTS,
    parameter int PB = PORT_BITS,
    localparam int L = NP * PB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [L-1:0]  hit,
    input  logic [L-1:0]  en,
    input  logic [NP-1:0] id_wr,
    input  logic [PB-1:0] wdata,
    output logic [L-1:0]  id,
    output logic [NP-1:0] pending
);
    logic [L-1:0] keep;
    logic [L-1:0] fresh;

    for (genvar g = 0; g < NP; g++) begin : g_port
        assign keep[g*PB +: PB] = id_wr[g] ? wdata : {PB{1'b1}};
        assign pending[g]       = |id[g*PB +: PB];
    end

    assign fresh = hit & en;

    // new events win over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) id <= '0;
        else     id <= (id & keep) | fresh;
    end

    assert_masked_line_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((id & ~$past(id) & ~$past(en)) == '0));

    assert_edge_kept_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(hit & en) & ~id) == '0));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (id_wr == '0) |=> (($past(id) & ~id) == '0));

    assert_id_reset_R1: assert property (@(posedge clk)
        rst |=> (id == '0));
endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
    import eirq_pkg::*;
#(
    parameter int NP = NUM_PORTS,
    parameter int PB = PORT_BITS,
    localparam int L = NP * PB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PB-1:0]     bus_wdata,
    output logic [PB-1:0]     bus_rdata,
    input  logic [L-1:0]      line_in,
    output logic              irq
);
    host_req_t     req;
    page_e         page;
    logic [L-1:0]  pol;
    logic [L-1:0]  en;
    logic [L-1:0]  id;
    logic [L-1:0]  hit;
    logic [NP-1:0] id_wr;
    logic [NP-1:0] pending;

    assign req.wr   = bus_wr;
    assign req.addr = bus_addr;
    assign req.data = bus_wdata;

    eirq_cfg #(.NP(NP), .PB(PB)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .page  (page),
        .pol   (pol),
        .en    (en),
        .id_wr (id_wr)
    );

    eirq_edge #(.W(L)) u_edge (
        .clk (clk),
        .rst (rst),
        .pin (line_in),
        .pol (pol),
        .hit (hit)
    );

    eirq_latch #(.NP(NP), .PB(PB)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .en      (en),
        .id_wr   (id_wr),
        .wdata   (bus_wdata),
        .id      (id),
        .pending (pending)
    );

    assign irq = |pending;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_PENDING)
            bus_rdata[NP-1:0] = pending;
        if (bus_addr == OFS_PAGE)
            bus_rdata[PB-1 -: PAGE_W] = page;
        for (int p = 0; p < NP; p++) begin
            if (bus_addr == win_addr(p)) begin
                case (page)
                    PG_POL:  bus_rdata = pol[p*PB +: PB];
                    PG_ENA:  bus_rdata = en[p*PB +: PB];
                    PG_ID:   bus_rdata = id[p*PB +: PB];
                    default: bus_rdata = '0;
                endcase
            end
        end
    end

    assert_irq_rise_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(hit & en) != '0));
endmodule

// File: tb/test_eirq_ctrl.sv
module test_eirq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [23:0] line_in = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    eirq_ctrl i_eirq_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_in(line_in), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic get(input logic [1:0] pg, input int port, output logic [7:0] d);
        wr(4'h7, {pg, 6'b0});
        rd(4'(8 + port), d);
    endtask

    task automatic put(input logic [1:0] pg, input int port, input logic [7:0] d);
        wr(4'h7, {pg, 6'b0});
        wr(4'(8 + port), d);
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1", "irq after reset", {31'b0, irq}, 0);
        rd(4'h7, v); chk("R1", "page after reset", v, 8'h00);
        rd(4'h6, v); chk("R1", "pending after reset", v, 8'h00);
        for (int p = 0; p < 3; p++) begin
            get(2'd1, p, v); chk("R1", "polarity after reset", v, 0);
            get(2'd2, p, v); chk("R1", "enable after reset", v, 0);
            get(2'd3, p, v); chk("R1", "events after reset", v, 0);
        end
    endtask

    task automatic t_page();
        logic [7:0] v;
        wr(4'h7, 8'hFF); rd(4'h7, v); chk("R2", "page readback all ones", v, 8'hC0);
        wr(4'h7, 8'h7F); rd(4'h7, v); chk("R2", "page readback 01", v, 8'h40);
    endtask

    task automatic t_cfg();
        logic [7:0] v;
        put(2'd1, 0, 8'hA5); put(2'd1, 1, 8'h3C); put(2'd1, 2, 8'h0F);
        put(2'd2, 0, 8'h11); put(2'd2, 1, 8'h22); put(2'd2, 2, 8'h44);
        get(2'd1, 0, v); chk("R3", "polarity byte 0", v, 8'hA5);
        get(2'd1, 1, v); chk("R3", "polarity byte 1", v, 8'h3C);
        get(2'd1, 2, v); chk("R3", "polarity byte 2", v, 8'h0F);
        get(2'd2, 0, v); chk("R4", "enable byte 0", v, 8'h11);
        get(2'd2, 1, v); chk("R4", "enable byte 1", v, 8'h22);
        get(2'd2, 2, v); chk("R4", "enable byte 2", v, 8'h44);
        for (int p = 0; p < 3; p++) begin
            put(2'd1, p, 8'h00); put(2'd2, p, 8'h00);
        end
    endtask

    task automatic t_edges();
        logic [7:0] v;
        put(2'd1, 1, 8'hFF); put(2'd2, 1, 8'hFF);
        @(negedge clk); line_in[9] = 1'b1; settle();
        get(2'd3, 1, v); chk("R5", "rising on line 9", v, 8'h02);
        get(2'd3, 0, v); chk("R5", "port 0 untouched", v, 8'h00);
        rd(4'h6, v); chk("R10", "pending port 1", v, 8'h02);
        chk("R11", "irq with event", {31'b0, irq}, 1);
        wr(4'h9, 8'h00);
        get(2'd3, 1, v); chk("R8", "byte cleared", v, 8'h00);
        chk("R11", "irq after clear", {31'b0, irq}, 0);
        @(negedge clk); line_in[9] = 1'b0; settle();
        get(2'd3, 1, v); chk("R6", "falling ignored when rising selected", v, 8'h00);
        put(2'd2, 1, 8'h00);
        put(2'd1, 2, 8'h00); put(2'd2, 2, 8'h80);
        @(negedge clk); line_in[23] = 1'b1; settle();
        get(2'd3, 2, v); chk("R6", "rising ignored when falling selected", v, 8'h00);
        @(negedge clk); line_in[23] = 1'b0; settle();
        get(2'd3, 2, v); chk("R6", "falling on line 23", v, 8'h80);
        rd(4'h6, v); chk("R10", "pending port 2", v, 8'h04);
        wr(4'hA, 8'h00);
        put(2'd2, 2, 8'h00);
    endtask

    task automatic t_partial();
        logic [7:0] v;
        put(2'd1, 0, 8'h07); put(2'd2, 0, 8'h03);
        @(negedge clk); line_in[1:0] = 2'b11; settle();
        get(2'd3, 0, v); chk("R6", "two rising events", v, 8'h03);
        wr(4'h8, 8'hFE);
        rd(4'h8, v); chk("R8", "zero bit cleared, one bit kept", v, 8'h02);
        wr(4'h8, 8'hFF);
        rd(4'h8, v); chk("R8", "all-ones write sets nothing", v, 8'h02);
        chk("R11", "irq with remaining event", {31'b0, irq}, 1);
        @(negedge clk); line_in[2] = 1'b1; settle();
        get(2'd3, 0, v); chk("R7", "masked line 2", v, 8'h02);
        put(2'd2, 0, 8'h07); settle();
        get(2'd3, 0, v); chk("R7", "late enable latches nothing", v, 8'h02);
        rd(4'h6, v); chk("R10", "pending port 0 only", v, 8'h01);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        @(negedge clk); line_in[0] = 1'b0; settle();
        get(2'd3, 0, v); chk("R6", "setup before collision", v, 8'h02);
        @(negedge clk);
        line_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'h8; bus_wdata = 8'h00;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(4'h8, v); chk("R9", "edge kept under clear", v, 8'h01);
    endtask

    task automatic t_page0();
        logic [7:0] v;
        wr(4'h7, 8'h00);
        wr(4'h8, 8'hFF); wr(4'h9, 8'hFF); wr(4'hA, 8'hFF);
        rd(4'h8, v); chk("R12", "page 0 window reads zero", v, 8'h00);
        rd(4'h3, v); chk("R12", "port offset reads zero", v, 8'h00);
        wr(4'h6, 8'hFF);
        rd(4'h6, v); chk("R10", "pending unchanged by write", v, 8'h01);
        get(2'd1, 0, v); chk("R12", "polarity unchanged", v, 8'h07);
        get(2'd2, 1, v); chk("R12", "enable unchanged", v, 8'h00);
        get(2'd3, 0, v); chk("R12", "events unchanged", v, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_page();
        t_cfg();
        t_edges();
        t_partial();
        t_collide();
        t_page0();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end
endmodule